// File: doc/BRIEF.md
# Multi-Mode DMA Address and Frame Sequencer

This block is the address engine of one DMA channel. A transfer is a block of F frames, and each frame holds E elements. The block produces the source and destination addresses for each element and steps forward by one element on every `advance` strobe. Each side, source and destination, has its own addressing mode. A mode can hold the address still, step it by the element size, or add signed element and frame indices on top of that step. All address arithmetic wraps modulo 2^32.

The data path is limited to a value decision. A fill colour can replace the incoming data. In transparent mode, the destination write is dropped whenever the value equals the colour. Element and frame counters raise half-frame, last-frame, end-of-frame and end-of-block events during the cycle of the advance that causes them.

At the end of a block, a channel in the separate-index (non-legacy) mode stops and may ask for a linked channel to be started. A channel in legacy mode can stop, reload itself at once, or park until an end-program flag arrives and then reload.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset the sequencer is idle (`busy`=0, `waiting`=0), both addresses are 0, and no event or write strobe is active.
- R2: A `start` while idle is rejected when the element count is 0, the frame count is 0 or the size code is 3. A rejected start pulses `load_err` during its own cycle, and `busy` stays 0.
- R3: The element size is 1 << `cfg_size_code` bytes. Mode codes are 0 constant, 1 post-increment, 2 single-index and 3 double-index. The element delta is 0, the size, size+eidx-1 and size+eidx-1 for these modes. The frame delta is fidx-eidx in mode 3 and 0 in every other mode. Both indices are signed 16-bit values.
- R4: With `cfg_legacy`=1 the destination side uses the source index inputs. With `cfg_legacy`=0 it uses its own index inputs.
- R5: Each advance increments the element counter. `ev_half` fires when the new count equals E>>1. `ev_last` fires when the new count equals 1 in the final frame.
- R6: When the element count reaches E, the counter returns to 0, the frame delta is added on top of the element delta, the frame counter increments and `ev_frame` fires. After the last frame, `ev_block` fires as well.
- R7: At end of block with `cfg_legacy`=0 the channel goes idle. If `cfg_link_en`=1, `link_req` pulses with `link_ch` = `cfg_link_ch` during that advance.
- R8: At end of block with `cfg_legacy`=1 the channel behaves as follows. With auto-init off, it goes idle. With auto-init on and either repeat or end-program set, it reloads addresses and counters from the configuration and stays busy. Otherwise it sets `waiting`, and it reloads once `cfg_end_prog` is seen high.
- R9: With fill enabled, `data_out` is `cfg_color`. With transparent copy enabled, `wr_en` is 0 for an advance whose value equals `cfg_color`. In every other case `wr_en` follows each accepted advance.
- R10: `advance` while idle changes no address and raises no write. `start` while busy is ignored.
- R11: Address additions wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_base | input | 32 | Source start address |
| cfg_dst_base | input | 32 | Destination start address |
| cfg_elem_cnt | input | 16 | Elements per frame (E) |
| cfg_frame_cnt | input | 16 | Frames per block (F) |
| cfg_src_eidx | input | 16 | Source signed element index |
| cfg_src_fidx | input | 16 | Source signed frame index |
| cfg_dst_eidx | input | 16 | Destination signed element index |
| cfg_dst_fidx | input | 16 | Destination signed frame index |
| cfg_size_code | input | 2 | Element size code |
| cfg_src_mode | input | 2 | Source addressing mode |
| cfg_dst_mode | input | 2 | Destination addressing mode |
| cfg_legacy | input | 1 | Shared indices and auto-init end-of-block handling |
| cfg_fill_en | input | 1 | Replace data with colour |
| cfg_transp_en | input | 1 | Drop writes that match colour |
| cfg_color | input | 32 | Fill / transparency colour |
| cfg_auto_init | input | 1 | Legacy auto-init enable |
| cfg_repeat | input | 1 | Legacy immediate reload |
| cfg_end_prog | input | 1 | End-program flag |
| cfg_link_en | input | 1 | Request linked channel at block end |
| cfg_link_ch | input | 4 | Linked channel number |
| start | input | 1 | Load configuration and begin |
| advance | input | 1 | One element transferred |
| data_in | input | 32 | Value read from the source |
| busy | output | 1 | Channel active |
| waiting | output | 1 | Parked, awaiting end-program |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| data_out | output | 32 | Value to write |
| wr_en | output | 1 | Destination write enable |
| ev_half | output | 1 | Half-frame event |
| ev_last | output | 1 | Last-frame event |
| ev_frame | output | 1 | End-of-frame event |
| ev_block | output | 1 | End-of-block event |
| link_req | output | 1 | Start the linked channel |
| link_ch | output | 4 | Linked channel number |
| load_err | output | 1 | Start rejected |

## Verification
The hardest state to reach is the parked legacy channel. It needs auto-init on, repeat and end-program both off, and a whole block stepped through, before `cfg_end_prog` can be raised to release it. The bench programs a two-element single-frame block so that the park comes after two advances. It then checks `waiting`, the idle state and the address that was not reset, raises end-program, and confirms that the reload restores the base address. Mixed-mode address sequences are compared with a closed-form model: base + n·edelta + ⌊n/E⌋·fdelta.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   typedef enum logic [1:0] {
      AM_CONST   = 2'd0,
      AM_POSTINC = 2'd1,
      AM_SINGLE  = 2'd2,
      AM_DOUBLE  = 2'd3
   } addr_mode_e;
endpackage

// File: rtl/dma_seq_delta.sv
module dma_seq_delta
   import dma_seq_pkg::*;
#(
   parameter int AW = 32,
   parameter int IW = 16
) (
   input  logic [1:0]    mode,
   input  logic [1:0]    size_code,
   input  logic [IW-1:0] eidx,
   input  logic [IW-1:0] fidx,
   output logic [AW-1:0] edelta,
   output logic [AW-1:0] fdelta
);
   logic [AW-1:0] size_b, e_ext, f_ext;

   always_comb begin
      size_b = AW'(1) << size_code;
      e_ext  = AW'($signed(eidx));
      f_ext  = AW'($signed(fidx));
      edelta = '0;
      fdelta = '0;
      case (addr_mode_e'(mode))
         AM_CONST:   edelta = '0;
         AM_POSTINC: edelta = size_b;
         AM_SINGLE:  edelta = size_b + e_ext - AW'(1);
         AM_DOUBLE: begin
            edelta = size_b + e_ext - AW'(1);
            fdelta = f_ext - e_ext;
         end
         default: edelta = '0;
      endcase
   end
endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [CW-1:0] elems,
   input  logic [CW-1:0] frames,
   output logic          ev_half,
   output logic          ev_last,
   output logic          ev_frame,
   output logic          ev_block
);
   logic [CW-1:0] elem_q, frame_q, elem_nx;
   logic          frame_end, final_frame;

   assign elem_nx     = elem_q + CW'(1);
   assign frame_end   = (elem_nx == elems);
   assign final_frame = (frame_q == frames - CW'(1));
   assign ev_half     = step && (elem_nx == (elems >> 1));
   assign ev_last     = step && (elem_nx == CW'(1)) && final_frame;
   assign ev_frame    = step && frame_end;
   assign ev_block    = ev_frame && final_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elem_q  <= '0;
         frame_q <= '0;
      end else if (clr) begin
         elem_q  <= '0;
         frame_q <= '0;
      end else if (step) begin
         if (frame_end) begin
            elem_q  <= '0;
            frame_q <= final_frame ? '0 : frame_q + CW'(1);
         end else begin
            elem_q <= elem_nx;
         end
      end
   end
endmodule

// File: rtl/dma_seq_data.sv
module dma_seq_data #(
   parameter int DW = 32
) (
   input  logic          step,
   input  logic          fill_en,
   input  logic          transp_en,
   input  logic [DW-1:0] color,
   input  logic [DW-1:0] data_in,
   output logic [DW-1:0] data_out,
   output logic          wr_en
);
   assign data_out = fill_en ? color : data_in;
   assign wr_en    = step && !(transp_en && (data_out == color));
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
   parameter int AW = 32,
   parameter int CW = 16,
   parameter int IW = 16,
   parameter int DW = 32,
   parameter int LW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cfg_src_base,
   input  logic [AW-1:0] cfg_dst_base,
   input  logic [CW-1:0] cfg_elem_cnt,
   input  logic [CW-1:0] cfg_frame_cnt,
   input  logic [IW-1:0] cfg_src_eidx,
   input  logic [IW-1:0] cfg_src_fidx,
   input  logic [IW-1:0] cfg_dst_eidx,
   input  logic [IW-1:0] cfg_dst_fidx,
   input  logic [1:0]    cfg_size_code,
   input  logic [1:0]    cfg_src_mode,
   input  logic [1:0]    cfg_dst_mode,
   input  logic          cfg_legacy,
   input  logic          cfg_fill_en,
   input  logic          cfg_transp_en,
   input  logic [DW-1:0] cfg_color,
   input  logic          cfg_auto_init,
   input  logic          cfg_repeat,
   input  logic          cfg_end_prog,
   input  logic          cfg_link_en,
   input  logic [LW-1:0] cfg_link_ch,
   input  logic          start,
   input  logic          advance,
   input  logic [DW-1:0] data_in,
   output logic          busy,
   output logic          waiting,
   output logic [AW-1:0] src_addr,
   output logic [AW-1:0] dst_addr,
   output logic [DW-1:0] data_out,
   output logic          wr_en,
   output logic          ev_half,
   output logic          ev_last,
   output logic          ev_frame,
   output logic          ev_block,
   output logic          link_req,
   output logic [LW-1:0] link_ch,
   output logic          load_err
);
   localparam int NSIDE = 2;

   if (AW < IW) begin : g_chk_aw
      $error("address width must cover the index width");
   end
   if (CW < 2) begin : g_chk_cw
      $error("count width too small");
   end
   if (LW < 1 || DW < 8) begin : g_chk_misc
      $error("link or data width too small");
   end

   logic [1:0]    side_mode [NSIDE];
   logic [IW-1:0] side_eidx [NSIDE];
   logic [IW-1:0] side_fidx [NSIDE];
   logic [AW-1:0] ed_c [NSIDE], fd_c [NSIDE];
   logic [AW-1:0] ed_q [NSIDE], fd_q [NSIDE], addr_q [NSIDE];
   logic [CW-1:0] elems_q, frames_q;
   logic          busy_q, wait_q;

   assign side_mode[0] = cfg_src_mode;
   assign side_mode[1] = cfg_dst_mode;
   assign side_eidx[0] = cfg_src_eidx;
   assign side_fidx[0] = cfg_src_fidx;
   assign side_eidx[1] = cfg_legacy ? cfg_src_eidx : cfg_dst_eidx;
   assign side_fidx[1] = cfg_legacy ? cfg_src_fidx : cfg_dst_fidx;

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      dma_seq_delta #(.AW(AW), .IW(IW)) u_delta (
         .mode     (side_mode[s]),
         .size_code(cfg_size_code),
         .eidx     (side_eidx[s]),
         .fidx     (side_fidx[s]),
         .edelta   (ed_c[s]),
         .fdelta   (fd_c[s])
      );
   end

   logic step, cfg_bad, reload_blk, load_req, load_ok;

   assign step       = advance && busy_q;
   assign cfg_bad    = (cfg_elem_cnt == '0) || (cfg_frame_cnt == '0) || (cfg_size_code == 2'd3);
   assign reload_blk = ev_block && cfg_legacy && cfg_auto_init && (cfg_repeat || cfg_end_prog);
   assign load_req   = (start && !busy_q) || (wait_q && cfg_end_prog) || reload_blk;
   assign load_ok    = load_req && !cfg_bad;
   assign load_err   = load_req && cfg_bad;

   dma_seq_count #(.CW(CW)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (load_req),
      .step    (step),
      .elems   (elems_q),
      .frames  (frames_q),
      .ev_half (ev_half),
      .ev_last (ev_last),
      .ev_frame(ev_frame),
      .ev_block(ev_block)
   );

   dma_seq_data #(.DW(DW)) u_data (
      .step     (step),
      .fill_en  (cfg_fill_en),
      .transp_en(cfg_transp_en),
      .color    (cfg_color),
      .data_in  (data_in),
      .data_out (data_out),
      .wr_en    (wr_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         wait_q   <= 1'b0;
         elems_q  <= '0;
         frames_q <= '0;
         for (int i = 0; i < NSIDE; i++) begin
            addr_q[i] <= '0;
            ed_q[i]   <= '0;
            fd_q[i]   <= '0;
         end
      end else if (load_ok) begin
         busy_q    <= 1'b1;
         wait_q    <= 1'b0;
         elems_q   <= cfg_elem_cnt;
         frames_q  <= cfg_frame_cnt;
         addr_q[0] <= cfg_src_base;
         addr_q[1] <= cfg_dst_base;
         for (int i = 0; i < NSIDE; i++) begin
            ed_q[i] <= ed_c[i];
            fd_q[i] <= fd_c[i];
         end
      end else if (load_err) begin
         busy_q <= 1'b0;
         wait_q <= 1'b0;
      end else if (step) begin
         for (int i = 0; i < NSIDE; i++)
            addr_q[i] <= addr_q[i] + ed_q[i] + (ev_frame ? fd_q[i] : '0);
         if (ev_block) begin
            busy_q <= 1'b0;
            wait_q <= cfg_legacy && cfg_auto_init;
         end
      end
   end

   assign busy     = busy_q;
   assign waiting  = wait_q;
   assign src_addr = addr_q[0];
   assign dst_addr = addr_q[1];
   assign link_req = ev_block && !cfg_legacy && cfg_link_en;
   assign link_ch  = cfg_link_ch;
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          waiting,
   input logic          advance,
   input logic [AW-1:0] src_addr,
   input logic [AW-1:0] dst_addr,
   input logic          ev_frame,
   input logic          ev_block,
   input logic          link_req,
   input logic          load_err,
   input logic          wr_en,
   input logic [DW-1:0] data_out,
   input logic [DW-1:0] cfg_color,
   input logic          cfg_transp_en,
   input logic          cfg_legacy,
   input logic          cfg_auto_init,
   input logic          cfg_repeat,
   input logic          cfg_end_prog
);
   AST_BAD_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |=> !busy); // R2
   AST_BLOCK_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      ev_block |-> ev_frame); // R6
   AST_NEW_STYLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_block && !cfg_legacy) |=> !busy); // R7
   AST_LINK_AT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      link_req |-> ev_block); // R7
   AST_NOAUTO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_block && cfg_legacy && !cfg_auto_init) |=> (!busy && !waiting)); // R8
   AST_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_block && cfg_legacy && cfg_auto_init && !cfg_repeat && !cfg_end_prog) |=> waiting); // R8
   AST_TRANSP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cfg_transp_en) |-> (data_out != cfg_color)); // R9
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_en); // R10
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !advance) |=> ($stable(src_addr) && $stable(dst_addr))); // R10
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .waiting      (waiting),
   .advance      (advance),
   .src_addr     (src_addr),
   .dst_addr     (dst_addr),
   .ev_frame     (ev_frame),
   .ev_block     (ev_block),
   .link_req     (link_req),
   .load_err     (load_err),
   .wr_en        (wr_en),
   .data_out     (data_out),
   .cfg_color    (cfg_color),
   .cfg_transp_en(cfg_transp_en),
   .cfg_legacy   (cfg_legacy),
   .cfg_auto_init(cfg_auto_init),
   .cfg_repeat   (cfg_repeat),
   .cfg_end_prog (cfg_end_prog)
);

// File: tb/dma_addr_seq_bench.sv
module dma_addr_seq_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic [31:0] cfg_src_base, cfg_dst_base, cfg_color, data_in;
   logic [15:0] cfg_elem_cnt, cfg_frame_cnt, cfg_src_eidx, cfg_src_fidx, cfg_dst_eidx, cfg_dst_fidx;
   logic [1:0]  cfg_size_code, cfg_src_mode, cfg_dst_mode;
   logic        cfg_legacy, cfg_fill_en, cfg_transp_en, cfg_auto_init, cfg_repeat, cfg_end_prog, cfg_link_en;
   logic [3:0]  cfg_link_ch;
   logic        start, advance;
   logic        busy, waiting, wr_en, ev_half, ev_last, ev_frame, ev_block, link_req, load_err;
   logic [31:0] src_addr, dst_addr, data_out;
   logic [3:0]  link_ch;

   dma_addr_seq u_dma_addr_seq (.*);

   int total = 0, bad = 0;
   logic s_half, s_last, s_frame, s_block, s_link, s_wr, s_err;
   logic [31:0] s_dout;
   logic [3:0]  s_lch;

   typedef struct packed {
      logic [1:0]  code, sm, dm;
      logic [15:0] se, sf, de, df, ne, nf, na;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{2'd0, 2'd0, 2'd1, 16'd0,    16'd0,    16'd0,    16'd0, 16'd4, 16'd3, 16'd6},
      '{2'd1, 2'd1, 2'd2, 16'd0,    16'd0,    16'd3,    16'd0, 16'd3, 16'd4, 16'd7},
      '{2'd2, 2'd3, 2'd3, 16'd2,    16'd10,   16'hFFFC, 16'd8, 16'd5, 16'd3, 16'd12},
      '{2'd2, 2'd2, 2'd0, 16'd0,    16'd0,    16'd0,    16'd0, 16'd2, 16'd8, 16'd9},
      '{2'd1, 2'd3, 2'd1, 16'hFFFF, 16'hFFEC, 16'd0,    16'd0, 16'd6, 16'd2, 16'd8}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_addr(input logic [31:0] base, input logic [1:0] mode,
         input logic [1:0] code, input logic [15:0] ei, input logic [15:0] fi, input int e, input int n);
      logic [31:0] sz, ed, fd, eix, fix;
      sz  = 32'd1 << code;
      eix = {{16{ei[15]}}, ei};
      fix = {{16{fi[15]}}, fi};
      ed  = (mode == 2'd0) ? 32'd0 : (mode == 2'd1) ? sz : sz + eix - 32'd1;
      fd  = (mode == 2'd3) ? fix - eix : 32'd0;
      return base + 32'(n) * ed + 32'(n / e) * fd;
   endfunction

   task automatic cfg_default;
      cfg_src_base = 32'h0; cfg_dst_base = 32'h0; cfg_color = 32'hA5A5A5A5; data_in = 32'h0;
      cfg_elem_cnt = 16'd4; cfg_frame_cnt = 16'd1;
      cfg_src_eidx = 16'd0; cfg_src_fidx = 16'd0; cfg_dst_eidx = 16'd0; cfg_dst_fidx = 16'd0;
      cfg_size_code = 2'd0; cfg_src_mode = 2'd1; cfg_dst_mode = 2'd1;
      cfg_legacy = 1'b0; cfg_fill_en = 1'b0; cfg_transp_en = 1'b0; cfg_auto_init = 1'b0;
      cfg_repeat = 1'b0; cfg_end_prog = 1'b0; cfg_link_en = 1'b0; cfg_link_ch = 4'd0;
   endtask

   task automatic do_adv;
      advance = 1'b1;
      #2;
      s_half = ev_half; s_last = ev_last; s_frame = ev_frame; s_block = ev_block;
      s_link = link_req; s_lch = link_ch; s_wr = wr_en; s_dout = data_out;
      @(negedge clk);
      advance = 1'b0;
   endtask

   task automatic do_start;
      start = 1'b1;
      #2;
      s_err = load_err;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic drain;
      while (busy) do_adv();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int hc, fc, eh, e_n, n_n;
      logic [31:0] a0;
      rst_n = 1'b0; start = 1'b0; advance = 1'b0;
      cfg_default();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy", {31'd0, busy}, 32'd0);
      chk("R1 waiting", {31'd0, waiting}, 32'd0);
      chk("R1 src", src_addr, 32'd0);
      chk("R1 dst", dst_addr, 32'd0);
      chk("R1 events", {28'd0, ev_half, ev_last, ev_frame, ev_block}, 32'd0);

      // R10 advance while idle
      do_adv();
      chk("R10 idle wr", {31'd0, s_wr}, 32'd0);
      chk("R10 idle src", src_addr, 32'd0);

      // R2 rejected loads
      cfg_elem_cnt = 16'd0; do_start();
      chk("R2 zero elems err", {31'd0, s_err}, 32'd1);
      chk("R2 zero elems busy", {31'd0, busy}, 32'd0);
      cfg_elem_cnt = 16'd4; cfg_frame_cnt = 16'd0; do_start();
      chk("R2 zero frames err", {31'd0, s_err}, 32'd1);
      cfg_frame_cnt = 16'd1; cfg_size_code = 2'd3; do_start();
      chk("R2 size code 3 err", {31'd0, s_err}, 32'd1);
      chk("R2 size code 3 busy", {31'd0, busy}, 32'd0);

      // R3 R5 R6 table of mixed modes
      for (int v = 0; v < 5; v++) begin
         cfg_default();
         cfg_size_code = VECS[v].code; cfg_src_mode = VECS[v].sm; cfg_dst_mode = VECS[v].dm;
         cfg_src_eidx = VECS[v].se; cfg_src_fidx = VECS[v].sf;
         cfg_dst_eidx = VECS[v].de; cfg_dst_fidx = VECS[v].df;
         cfg_elem_cnt = VECS[v].ne; cfg_frame_cnt = VECS[v].nf;
         cfg_src_base = 32'h1000 + 32'(v) * 32'h100; cfg_dst_base = 32'h8000;
         e_n = int'(VECS[v].ne); n_n = int'(VECS[v].na);
         do_start();
         hc = 0; fc = 0; eh = 0;
         for (int k = 1; k <= n_n; k++) begin
            do_adv();
            hc += int'(s_half); fc += int'(s_frame);
            if (((k - 1) % e_n) + 1 == (e_n >> 1)) eh++;
         end
         chk("R3 src addr", src_addr, model_addr(cfg_src_base, cfg_src_mode, cfg_size_code,
             cfg_src_eidx, cfg_src_fidx, e_n, n_n));
         chk("R3 dst addr", dst_addr, model_addr(cfg_dst_base, cfg_dst_mode, cfg_size_code,
             cfg_dst_eidx, cfg_dst_fidx, e_n, n_n));
         chk("R6 frame events", 32'(fc), 32'(n_n / e_n));
         chk("R5 half events", 32'(hc), 32'(eh));
         drain();
         chk("R7 idle after block", {31'd0, busy}, 32'd0);
      end

      // R4 legacy shares source indices
      cfg_default();
      cfg_legacy = 1'b1; cfg_src_mode = 2'd0; cfg_dst_mode = 2'd2;
      cfg_src_eidx = 16'd5; cfg_dst_eidx = 16'd0; cfg_dst_base = 32'h400;
      do_start(); do_adv();
      chk("R4 legacy dst", dst_addr, 32'h405);
      drain();
      cfg_legacy = 1'b0; do_start(); do_adv();
      chk("R4 separate dst", dst_addr, 32'h400);
      drain();

      // R5 R6 R7 event positions on E=4 F=2, with link
      cfg_default();
      cfg_frame_cnt = 16'd2; cfg_link_en = 1'b1; cfg_link_ch = 4'd9;
      do_start();
      for (int k = 1; k <= 8; k++) begin
         do_adv();
         chk("R5 last-frame position", {31'd0, s_last}, {31'd0, k == 5});
         if (k == 6) chk("R5 half in frame 2", {31'd0, s_half}, 32'd1);
         if (k == 4) chk("R6 frame not block", {30'd0, s_frame, s_block}, 32'd2);
         if (k == 8) begin
            chk("R7 block+link", {29'd0, s_block, s_link, s_frame}, 32'd7);
            chk("R7 link channel", {28'd0, s_lch}, 32'd9);
         end
      end
      chk("R7 stopped", {31'd0, busy}, 32'd0);

      // R10 start while busy ignored
      cfg_default();
      cfg_src_base = 32'h200; do_start(); do_adv();
      cfg_src_base = 32'h900; do_start();
      chk("R10 start ignored", src_addr, 32'h201);
      drain();

      // R8 legacy end-of-block handling
      cfg_default();
      cfg_legacy = 1'b1; cfg_elem_cnt = 16'd2; cfg_src_base = 32'h100;
      do_start(); do_adv(); do_adv();
      chk("R8 no auto-init idle", {30'd0, busy, waiting}, 32'd0);
      cfg_auto_init = 1'b1; cfg_repeat = 1'b1;
      do_start(); do_adv();
      chk("R8 repeat mid", src_addr, 32'h101);
      do_adv();
      chk("R8 repeat reload addr", src_addr, 32'h100);
      chk("R8 repeat busy", {31'd0, busy}, 32'd1);
      cfg_repeat = 1'b0;
      do_adv(); do_adv();
      chk("R8 parked", {30'd0, busy, waiting}, 32'd1);
      a0 = src_addr;
      chk("R8 parked addr", a0, 32'h102);
      cfg_end_prog = 1'b1;
      @(negedge clk);
      cfg_end_prog = 1'b0;
      chk("R8 end-prog resume", {30'd0, busy, waiting}, 32'd2);
      chk("R8 end-prog reload", src_addr, 32'h100);
      cfg_auto_init = 1'b0;
      drain();

      // R9 fill and transparent copy
      cfg_default();
      cfg_elem_cnt = 16'd8;
      do_start();
      cfg_fill_en = 1'b1; data_in = 32'h55;
      do_adv();
      chk("R9 fill value", s_dout, 32'hA5A5A5A5);
      chk("R9 fill write", {31'd0, s_wr}, 32'd1);
      cfg_fill_en = 1'b0; cfg_transp_en = 1'b1; data_in = 32'hA5A5A5A5;
      do_adv();
      chk("R9 transparent drop", {31'd0, s_wr}, 32'd0);
      data_in = 32'h1234;
      do_adv();
      chk("R9 transparent pass", {31'd0, s_wr}, 32'd1);
      chk("R9 pass value", s_dout, 32'h1234);
      cfg_transp_en = 1'b0;
      drain();

      // R11 wrap
      cfg_default();
      cfg_size_code = 2'd2; cfg_src_base = 32'hFFFF_FFFE;
      do_start(); do_adv();
      chk("R11 wrap", src_addr, 32'h0000_0002);
      drain();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule